// File: doc/BRIEF.md
# Two-Wire Slave Byte Store

This block is a two-wire serial (I2C) slave that sits in front of a 256-entry by 8-bit register-file array. A fast system clock oversamples the bus clock and data lines. Each line passes through a two-stage synchronizer and a majority-free glitch filter before start, stop and edge events are derived. The block answers to a 7-bit device address made of a fixed 4-bit type field and three strap inputs. It keeps one word pointer that advances after every byte moved in either direction.

Three transactions are supported. A write sets the pointer from a word-address byte and then loads up to eight data bytes into a staging buffer. A random read sets the pointer the same way and then issues a repeated start followed by a read control byte. A short read streams bytes from wherever the pointer was left. Staged bytes are copied into the array when the stop condition arrives. A programming timer, clocked through a divide-by-128 prescaler, then holds the device busy. While it is busy the device does not answer its address.

The controller is an enumerated state machine:

- `ST_IDLE` waits for a start.
- `ST_CTRL` shifts in the control byte. It moves to `ST_CTRL_ACK` on an address hit, or to `ST_IGNORE` on a miss or while busy.
- `ST_CTRL_ACK` leads to `ST_RD_BIT` for a read or to `ST_WADDR` for a write.
- `ST_WADDR` leads to `ST_WADDR_ACK`, which leads to `ST_WDATA`.
- `ST_WDATA` moves to `ST_WDATA_ACK` while the buffer has room, and to `ST_IGNORE` when it is full. `ST_WDATA_ACK` returns to `ST_WDATA`.
- `ST_RD_BIT` leads to `ST_RD_ACK`. `ST_RD_ACK` returns to `ST_RD_BIT` if the master acknowledged, and goes to `ST_IGNORE` if it did not.
- A stop from any state returns to `ST_IDLE`. A start from any state enters `ST_CTRL`.

Top module: `serial_byte_store`

## Requirements
- R1: After reset the array holds 0x00 in every entry, the word pointer is 0, the device is not busy, and `sda_pull_o` is low.
- R2: A control byte is accepted only when its bits [7:4] equal 4'b1010, its bits [3:1] equal `dev_sel_i` and the device is not busy. Bit 0 is the direction: 1 means read, 0 means write. On a miss the device never pulls SDA low and ignores all later bytes until the next start or stop.
- R3: In a write, the device acknowledges the word-address byte and every buffered data byte. After the stop, the data bytes appear at consecutive array addresses from the word address, and the address wraps from 255 to 0.
- R4: A write transaction buffers at most 8 data bytes. A ninth or later data byte is not acknowledged and is not stored.
- R5: A stop that ends a write holding at least one buffered byte commits the buffer. The device is then busy for PROG_TICKS x 128 system clocks and does not acknowledge a control byte during that time. After that time it acknowledges again.
- R6: A random read (write control byte, word address, repeated start, read control byte) returns the byte stored at the word address, MSB first.
- R7: A short read (start, then read control byte) returns data from the current pointer. After a write the pointer is the word address plus the number of buffered bytes. After a read it is one past the last byte sent.
- R8: A read burst continues while the master acknowledges and wraps from 255 to 0. After a byte the master leaves unacknowledged, the device releases SDA and stays released.
- R9: A start condition in the middle of a byte aborts the transfer and restarts control-byte matching. Data bytes buffered but not yet committed are discarded, and no busy interval follows.
- R10: The device changes its SDA drive only while SCL is low. A bus-clock pulse shorter than FILT_LEN system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| dev_sel_i | input | 3 | Strap value matched against control byte bits [3:1] |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Several properties are checked on every cycle by the assertions. The device never drives SDA in the idle or ignore states. A new drive level only appears while the filtered SCL is low. The staging count never exceeds eight. Every start lands in control-byte matching. The programming timer is only launched while idle and is busy the cycle after launch. Other behaviours can only be shown by the bench's bus transactions: data placement and address wrap, the eight-byte limit, the length of the busy window, pointer continuity for short reads, the discard on an aborted write, and immunity to clock glitches.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RD_BIT,
        ST_RD_ACK,
        ST_IGNORE
    } ssb_state_e;

endpackage

// File: rtl/ssb_line_filter.sv
module ssb_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    // Output follows the line only after FILT_LEN agreeing samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            hist_q <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q) begin
                line_o <= 1'b1;
            end else if (~|hist_q) begin
                line_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ssb_prog_timer.sv
module ssb_prog_timer #(
    parameter int PRESCALE   = 128,
    parameter int PROG_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int PS_W = $clog2(PRESCALE);
    localparam int TK_W = $clog2(PROG_TICKS + 1);

    logic [PS_W-1:0] ps_q;
    logic [TK_W-1:0] left_q;
    logic            tick;

    assign tick   = (ps_q == PS_W'(PRESCALE - 1));
    assign busy_o = (left_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q   <= '0;
            left_q <= '0;
        end else if (start_i) begin
            ps_q   <= '0;
            left_q <= TK_W'(PROG_TICKS);
        end else if (left_q != '0) begin
            ps_q <= tick ? '0 : ps_q + 1'b1;
            if (tick) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    // R5: a launch is followed by a busy interval
    assert_launch_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R5: the controller only launches a commit when no interval is running
    assert_no_relaunch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R5: the interval ends only on a prescaler boundary
    assert_end_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(tick));

endmodule

// File: rtl/ssb_regfile.sv
module ssb_regfile #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/serial_byte_store.sv
module serial_byte_store
    import ssb_pkg::*;
#(
    parameter int         MEM_DEPTH  = 256,
    parameter int         WBUF_DEPTH = 8,
    parameter int         PRESCALE   = 128,
    parameter int         PROG_TICKS = 8,
    parameter int         FILT_LEN   = 3,
    parameter logic [3:0] DEV_TYPE   = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    output logic       sda_pull_o
);

    localparam int AW   = $clog2(MEM_DEPTH);
    localparam int WC_W = $clog2(WBUF_DEPTH + 1);
    localparam int WI_W = $clog2(WBUF_DEPTH);

    // ---------------- line conditioning ----------------
    logic [1:0] raw_w;
    logic [1:0] filt_w;
    logic       scl_f, sda_f, scl_p, sda_p;

    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        ssb_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_w[g]),
            .line_o (filt_w[g])
        );
    end

    assign scl_f = filt_w[0];
    assign sda_f = filt_w[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    logic scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_rise = scl_f & ~scl_p;
    assign scl_fall = ~scl_f & scl_p;
    assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;

    // ---------------- state and datapath registers ----------------
    ssb_state_e           state_q, state_d;
    logic [3:0]           bit_cnt_q;
    logic [7:0]           rx_q, tx_q;
    logic                 rw_q, m_ack_q, pull_q;
    logic [AW-1:0]        ptr_q, wbase_q, commit_base_q;
    logic [WC_W-1:0]      wcnt_q, commit_left_q;
    logic [WI_W-1:0]      commit_idx_q;
    logic [7:0]           wbuf_q [WBUF_DEPTH];
    logic [7:0]           rd_data;
    logic                 busy_w, prog_go;
    logic                 byte_full, ctrl_hit, buf_room;

    assign byte_full = (bit_cnt_q == 4'd8);
    assign ctrl_hit  = (rx_q[7:1] == {DEV_TYPE, dev_sel_i}) && !busy_w;
    assign buf_room  = (wcnt_q < WC_W'(WBUF_DEPTH));
    assign prog_go   = stop_ev && (wcnt_q != '0);

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_CTRL;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_CTRL:      if (scl_fall && byte_full) state_d = ctrl_hit ? ST_CTRL_ACK : ST_IGNORE;
                ST_CTRL_ACK:  if (scl_fall) state_d = rw_q ? ST_RD_BIT : ST_WADDR;
                ST_WADDR:     if (scl_fall && byte_full) state_d = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_full) state_d = buf_room ? ST_WDATA_ACK : ST_IGNORE;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RD_BIT:    if (scl_fall && byte_full) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) state_d = m_ack_q ? ST_RD_BIT : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- datapath and output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q     <= '0;
            rx_q          <= '0;
            tx_q          <= '0;
            rw_q          <= 1'b0;
            m_ack_q       <= 1'b0;
            pull_q        <= 1'b0;
            ptr_q         <= '0;
            wbase_q       <= '0;
            wcnt_q        <= '0;
            commit_base_q <= '0;
            commit_left_q <= '0;
            commit_idx_q  <= '0;
            for (int i = 0; i < WBUF_DEPTH; i++) begin
                wbuf_q[i] <= '0;
            end
        end else begin
            if (commit_left_q != '0) begin
                commit_left_q <= commit_left_q - 1'b1;
                commit_idx_q  <= commit_idx_q + 1'b1;
            end
            if (start_ev || stop_ev) begin
                pull_q    <= 1'b0;
                bit_cnt_q <= '0;
                if (prog_go) begin
                    commit_left_q <= wcnt_q;
                    commit_idx_q  <= '0;
                    commit_base_q <= wbase_q;
                end
                wcnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_CTRL, ST_WADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_q      <= {rx_q[6:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (scl_fall && byte_full) begin
                            bit_cnt_q <= '0;
                            if (state_q == ST_CTRL) begin
                                rw_q   <= rx_q[0];
                                pull_q <= ctrl_hit;
                            end else if (state_q == ST_WADDR) begin
                                ptr_q   <= rx_q;
                                wbase_q <= rx_q;
                                pull_q  <= 1'b1;
                            end else if (buf_room) begin
                                wbuf_q[wcnt_q[WI_W-1:0]] <= rx_q;
                                wcnt_q <= wcnt_q + 1'b1;
                                ptr_q  <= ptr_q + 1'b1;
                                pull_q <= 1'b1;
                            end
                        end
                    end
                    ST_CTRL_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            pull_q    <= 1'b0;
                            bit_cnt_q <= '0;
                            if (state_q == ST_CTRL_ACK && rw_q) begin
                                tx_q   <= rd_data;
                                pull_q <= ~rd_data[7];
                            end
                        end
                    end
                    ST_RD_BIT: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (scl_fall) begin
                            if (byte_full) begin
                                pull_q    <= 1'b0;
                                ptr_q     <= ptr_q + 1'b1;
                                bit_cnt_q <= '0;
                                m_ack_q   <= 1'b0;
                            end else begin
                                tx_q   <= {tx_q[6:0], 1'b0};
                                pull_q <= ~tx_q[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            m_ack_q <= ~sda_f;
                        end
                        if (scl_fall && m_ack_q) begin
                            tx_q   <= rd_data;
                            pull_q <= ~rd_data[7];
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        pull_q <= 1'b0;
                    end
                    default: pull_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_pull_o = pull_q;

    // ---------------- array and programming timer ----------------
    ssb_regfile #(.DEPTH(MEM_DEPTH), .WIDTH(8)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (commit_left_q != '0),
        .waddr_i (commit_base_q + AW'(commit_idx_q)),
        .wdata_i (wbuf_q[commit_idx_q]),
        .raddr_i (ptr_q),
        .rdata_o (rd_data)
    );

    ssb_prog_timer #(.PRESCALE(PRESCALE), .PROG_TICKS(PROG_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_go),
        .busy_o  (busy_w)
    );

    // ---------------- assertions ----------------
    // R2: no drive while idle or after a rejected byte
    assert_quiet_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !sda_pull_o);

    // R10: a new pull-down only appears while the filtered clock is low
    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_f);

    // R4: staging count stays within the buffer
    assert_wbuf_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= WC_W'(WBUF_DEPTH));

    // R9: every start condition restarts control-byte matching
    assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> state_q == ST_CTRL);

    // R5: no control acknowledge while the programming interval runs
    assert_busy_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> state_q != ST_CTRL_ACK);

endmodule

// File: tb/serial_byte_store_tb.sv
`timescale 1ns/1ps
module serial_byte_store_tb;

    localparam int H          = 16;
    localparam int WBUF       = 8;
    localparam int PROG_TICKS = 8;
    localparam int BUSY_CYC   = PROG_TICKS * 128;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] CTRL_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] CTRL_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] exp_mem [256];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    serial_byte_store #(.PROG_TICKS(PROG_TICKS)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .dev_sel_i  (STRAP),
        .sda_pull_o (sda_pull)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic bus_stop;
        scl_m = 1'b0; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits, input bit glitch);
        for (int i = 7; i > 7 - nbits; i--) begin
            scl_m = 1'b0; wait_clk(H/2);
            sda_m = b[i]; wait_clk(H/2);
            if (glitch) begin
                scl_m = 1'b1; wait_clk(2);
                scl_m = 1'b0; wait_clk(H/2);
            end
            scl_m = 1'b1; wait_clk(H);
        end
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        send_bits(b, 8, glitch);
        wait_clk(H/2);
        sda_m = 1'b1; wait_clk(H/2);
        scl_m = 1'b1; wait_clk(H/2);
        ack = ~sda_line; wait_clk(H/2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; wait_clk(H);
            scl_m = 1'b1; wait_clk(H/2);
            b[i] = sda_line; wait_clk(H/2);
        end
        scl_m = 1'b0; wait_clk(H/2);
        sda_m = give_ack ? 1'b0 : 1'b1; wait_clk(H/2);
        scl_m = 1'b1; wait_clk(H);
        scl_m = 1'b0; wait_clk(H/2);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] wa, input int n, input logic [7:0] seed,
                            input bit glitch, input string tag);
        bit a;
        logic [7:0] d;
        bus_start;
        send_byte(CTRL_W, 1'b0, a); check({tag, " ctrl ack"}, a, 1);
        send_byte(wa, 1'b0, a);     check({tag, " word addr ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            d = 8'(seed + k * 29);
            send_byte(d, glitch, a);
            check({tag, " data ack"}, a, (k < WBUF) ? 1 : 0);
            if (k < WBUF) exp_mem[8'(wa + k)] = d;
        end
        bus_stop;
    endtask

    task automatic do_read(input logic [7:0] wa, input int n, input string tag);
        bit a;
        logic [7:0] d;
        bus_start;
        send_byte(CTRL_W, 1'b0, a); check({tag, " ctrl ack"}, a, 1);
        send_byte(wa, 1'b0, a);     check({tag, " word addr ack"}, a, 1);
        bus_start;
        send_byte(CTRL_R, 1'b0, a); check({tag, " read ctrl ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            check({tag, " read data"}, d, exp_mem[8'(wa + k)]);
        end
        wait_clk(H);
        check("R8 SDA released after master NACK", sda_pull, 0);
        bus_stop;
    endtask

    task automatic short_read(input logic [7:0] exp_addr, input string tag);
        bit a;
        logic [7:0] d;
        bus_start;
        send_byte(CTRL_R, 1'b0, a); check({tag, " short ctrl ack"}, a, 1);
        recv_byte(1'b0, d);
        check({tag, " short read data"}, d, exp_mem[exp_addr]);
        bus_stop;
    endtask

    initial begin
        bit a;
        logic [7:0] d;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(10);

        // R1: reset state
        check("R1 sda released after reset", sda_pull, 0);
        short_read(8'h00, "R1");

        // R2: wrong strap and wrong type are ignored
        bus_start;
        send_byte({4'b1010, 3'b011, 1'b0}, 1'b0, a); check("R2 strap mismatch nack", a, 0);
        send_byte(8'h00, 1'b0, a);                   check("R2 later byte ignored", a, 0);
        bus_stop;
        bus_start;
        send_byte({4'b0010, STRAP, 1'b1}, 1'b0, a);  check("R2 type mismatch nack", a, 0);
        wait_clk(H);
        check("R2 no drive after mismatch", sda_pull, 0);
        bus_stop;

        // R3: write four bytes
        do_write(8'h10, 4, 8'h5A, 1'b0, "R3");

        // R5: busy window
        bus_start;
        send_byte(CTRL_W, 1'b0, a); check("R5 nack while busy", a, 0);
        bus_stop;
        wait_clk(BUSY_CYC + 100);
        bus_start;
        send_byte(CTRL_W, 1'b0, a); check("R5 ack after interval", a, 1);
        bus_stop;

        // R6: random read back
        do_read(8'h10, 4, "R6");
        // R7: short read continues after the random read
        short_read(8'h14, "R7");

        // R4: write limit, then R7 pointer after write
        do_write(8'h40, 10, 8'hC3, 1'b0, "R4");
        wait_clk(BUSY_CYC + 100);
        short_read(8'h48, "R7 after write");
        do_read(8'h40, 10, "R4");

        // R3 / R8: wrap in write and in read burst
        do_write(8'hFE, 3, 8'h71, 1'b0, "R3 wrap");
        wait_clk(BUSY_CYC + 100);
        do_read(8'hFE, 4, "R8 wrap");

        // R9: start mid-byte aborts a write
        bus_start;
        send_byte(CTRL_W, 1'b0, a); check("R9 ctrl ack", a, 1);
        send_byte(8'h30, 1'b0, a);  check("R9 word addr ack", a, 1);
        send_byte(8'hEE, 1'b0, a);  check("R9 first data ack", a, 1);
        send_bits(8'hFF, 4, 1'b0);
        bus_start;
        send_byte(CTRL_R, 1'b0, a); check("R9 matching restarted", a, 1);
        recv_byte(1'b0, d);         check("R9 aborted byte not stored", d, exp_mem[8'h31]);
        bus_stop;
        bus_start;
        send_byte(CTRL_W, 1'b0, a); check("R9 no busy after abort", a, 1);
        bus_stop;
        do_read(8'h30, 2, "R9");

        // R10: short clock glitches ignored
        do_write(8'h60, 2, 8'h96, 1'b1, "R10");
        wait_clk(BUSY_CYC + 100);
        do_read(8'h60, 2, "R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule